// File: doc/BRIEF.md
# Address Register Bank

A bank of three 8-bit address registers with fixed roles: a program counter, a general address register and a stack pointer. A 3-bit enable mask picks which registers take part in an update. A 2-bit function code picks the update, which is one of clear, load from the shared 8-bit input, increment or decrement. Every register whose mask bit is set applies the same function on the same rising clock edge. Registers whose mask bit is clear keep their values.

Two read ports each show one register through their own 2-bit select, with no register in the path. The spare fourth select code shows the program counter, so every select value gives a defined output. The two read ports are independent of each other, so an instruction sequencer can read, for example, the stack pointer on one port and the program counter on the other in the same cycle.

Top module: `addr_reg_bank`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, all three registers become 8'h00 at that edge, whatever the other inputs are.
- R2: Mask bit 0 enables the program counter, bit 1 the address register and bit 2 the stack pointer. A register whose mask bit is 0 keeps its value across the edge, and a mask of 3'b000 changes no register.
- R3: Function code 2'b00 clears every enabled register to 8'h00 at the next rising edge.
- R4: Function code 2'b01 loads `data_in` into every enabled register at the next rising edge.
- R5: Function code 2'b10 adds one to every enabled register at the next rising edge, wrapping from 8'hFF to 8'h00.
- R6: Function code 2'b11 subtracts one from every enabled register at the next rising edge, wrapping from 8'h00 to 8'hFF.
- R7: `out_c` shows the program counter for `sel_c` 2'b00, the address register for 2'b01, the stack pointer for 2'b10 and the program counter for 2'b11. It follows the select and the register contents combinationally.
- R8: `out_d` uses the same mapping as R7, driven by `sel_d`, and does not depend on `sel_c`.
- R9: When several mask bits are set, every enabled register applies the function on the same edge. Each register starts from its own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Shared value used by the load function |
| reg_mask | input | 3 | Per-register enable: bit 0 program counter, bit 1 address register, bit 2 stack pointer |
| func_sel | input | 2 | 00 clear, 01 load, 10 increment, 11 decrement |
| sel_c | input | 2 | Read select for `out_c` |
| sel_d | input | 2 | Read select for `out_d` |
| out_c | output | 8 | Selected register, port C |
| out_d | output | 8 | Selected register, port D |

## Verification
Register updates are due one clock edge after the controls are presented. The bench therefore drives the mask, function and data on the falling edge, waits for the next rising edge, and samples 1 ns after it. Read-port results take zero cycles. The bench reads back all three registers by changing `sel_c` and `sel_d` and waiting 1 ns after each change, so that each read reflects only the select just written. Each register is read through both ports with different selects at the same time, which shows that the two ports are independent. A separate read of code 2'b11 on each port covers the alias to the program counter.

// File: rtl/addr_bank_pkg.sv
`timescale 1ns/1ps
// Package: shared function encoding for the address register bank.
// Assumes a 2-bit function code used identically by every register.
package addr_bank_pkg;

    typedef enum logic [1:0] {
        FN_CLR  = 2'b00,
        FN_LOAD = 2'b01,
        FN_INC  = 2'b10,
        FN_DEC  = 2'b11
    } bank_func_e;

endpackage

// File: rtl/addr_reg_cell.sv
`timescale 1ns/1ps
// Module: addr_reg_cell
// One address register that applies clear, load, increment or decrement when enabled.
// Assumes a synchronous active-low reset. Arithmetic wraps modulo 2**DATA_W.
module addr_reg_cell
    import addr_bank_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  bank_func_e        func,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Register update: reset first, then the selected function when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            case (func)
                FN_CLR:  q <= '0;
                FN_LOAD: q <= d;
                FN_INC:  q <= q + ONE;
                FN_DEC:  q <= q - ONE;
                default: q <= q;
            endcase
        end
    end

endmodule

// File: rtl/addr_out_mux.sv
`timescale 1ns/1ps
// Module: addr_out_mux
// Combinational read port. Select values beyond the last register fall back to register 0.
// Assumes register 0 is the program counter, which makes it the alias target.
module addr_out_mux #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 3,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [SEL_W-1:0]                sel,
    output logic [DATA_W-1:0]               out
);

    // Read selection: default to register 0, override on a matching code.
    always_comb begin
        out = regs_i[0];
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == SEL_W'(i)) out = regs_i[i];
        end
    end

endmodule

// File: rtl/addr_reg_bank.sv
`timescale 1ns/1ps
// Module: addr_reg_bank
// Three address registers (program counter, address register, stack pointer) with a
// per-register enable mask, a shared function code and two independent read ports.
// Assumes all controls are synchronous to clk. The reset is synchronous, active low.
module addr_reg_bank
    import addr_bank_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 3,
    parameter int SEL_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [NUM_REGS-1:0] reg_mask,
    input  logic [1:0]          func_sel,
    input  logic [SEL_W-1:0]    sel_c,
    input  logic [SEL_W-1:0]    sel_d,
    output logic [DATA_W-1:0]   out_c,
    output logic [DATA_W-1:0]   out_d
);

    localparam int PORTS = 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [PORTS-1:0][SEL_W-1:0]     port_sel;
    logic [PORTS-1:0][DATA_W-1:0]    port_out;
    bank_func_e                      func;

    assign func        = bank_func_e'(func_sel);
    assign port_sel[0] = sel_c;
    assign port_sel[1] = sel_d;
    assign out_c       = port_out[0];
    assign out_d       = port_out[1];

    // One storage cell per register, each gated by its own mask bit.
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        addr_reg_cell #(.DATA_W(DATA_W)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (reg_mask[r]),
            .func (func),
            .d    (data_in),
            .q    (regs_q[r])
        );
    end

    // One independent read multiplexer per output port.
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        addr_out_mux #(
            .DATA_W  (DATA_W),
            .NUM_REGS(NUM_REGS),
            .SEL_W   (SEL_W)
        ) u_mux (
            .regs_i(regs_q),
            .sel   (port_sel[p]),
            .out   (port_out[p])
        );
    end

endmodule

// File: rtl/addr_reg_bank_chk.sv
`timescale 1ns/1ps
// Module: addr_reg_bank_chk
// Assertion checker for addr_reg_bank, attached by bind.
// Assumes the three-register layout: index 0 program counter, 1 address register, 2 stack pointer.
module addr_reg_bank_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_in,
    input logic [2:0]        reg_mask,
    input logic [1:0]        func_sel,
    input logic [1:0]        sel_c,
    input logic [1:0]        sel_d,
    input logic [DATA_W-1:0] out_c,
    input logic [DATA_W-1:0] out_d,
    input logic [DATA_W-1:0] pc_q,
    input logic [DATA_W-1:0] ar_q,
    input logic [DATA_W-1:0] sp_q
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && ar_q == '0 && sp_q == '0)); // R1

    AST_MASK_HOLD_SP: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_mask[2] |=> $stable(sp_q)); // R2

    AST_CLEAR_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mask[0] && func_sel == 2'b00) |=> pc_q == '0); // R3

    AST_LOAD_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mask[0] && func_sel == 2'b01) |=> pc_q == $past(data_in)); // R4

    AST_INC_AR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mask[1] && func_sel == 2'b10) |=> ar_q == DATA_W'($past(ar_q) + 1'b1)); // R5

    AST_DEC_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mask[2] && func_sel == 2'b11) |=> sp_q == DATA_W'($past(sp_q) - 1'b1)); // R6

    AST_ALIAS_C: assert property (@(posedge clk) disable iff (!rst_n)
        sel_c == 2'b11 |-> out_c == pc_q); // R7

    AST_ALIAS_D: assert property (@(posedge clk) disable iff (!rst_n)
        sel_d == 2'b11 |-> out_d == pc_q); // R8

    AST_SP_PORT_D: assert property (@(posedge clk) disable iff (!rst_n)
        sel_d == 2'b10 |-> out_d == sp_q); // R8

endmodule

bind addr_reg_bank addr_reg_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_in (data_in),
    .reg_mask(reg_mask),
    .func_sel(func_sel),
    .sel_c   (sel_c),
    .sel_d   (sel_d),
    .out_c   (out_c),
    .out_d   (out_d),
    .pc_q    (regs_q[0]),
    .ar_q    (regs_q[1]),
    .sp_q    (regs_q[2])
);

// File: tb/sim_addr_reg_bank.sv
`timescale 1ns/1ps
// Bench: directed scenarios for addr_reg_bank, one task per scenario.
module sim_addr_reg_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = '0;
    logic [2:0] reg_mask = '0;
    logic [1:0] func_sel = '0;
    logic [1:0] sel_c = '0;
    logic [1:0] sel_d = '0;
    logic [7:0] out_c, out_d;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] model [3];

    always #2 clk = ~clk;

    addr_reg_bank u0 (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .reg_mask(reg_mask),
        .func_sel(func_sel), .sel_c(sel_c), .sel_d(sel_d),
        .out_c(out_c), .out_d(out_d)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Read every register through both ports, using different selects on each port.
    task automatic read_all(input string req);
        for (int i = 0; i < 3; i++) begin
            sel_c = 2'(i);
            sel_d = 2'((i + 1) % 3);
            #1;
            check({req, " R7 port C"}, out_c, model[i]);
            check({req, " R8 port D"}, out_d, model[(i + 1) % 3]);
        end
    endtask

    // Drive one operation on a falling edge, let it take effect, update the model.
    task automatic op(input logic [2:0] m, input logic [1:0] f, input logic [7:0] d);
        @(negedge clk);
        reg_mask = m; func_sel = f; data_in = d;
        @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) begin
            if (m[i]) begin
                case (f)
                    2'b00: model[i] = 8'h00;
                    2'b01: model[i] = d;
                    2'b10: model[i] = model[i] + 8'h01;
                    default: model[i] = model[i] - 8'h01;
                endcase
            end
        end
        reg_mask = '0;
    endtask

    task automatic t_reset();
        op(3'b111, 2'b01, 8'h5A);
        @(negedge clk);
        rst_n = 1'b0; reg_mask = 3'b111; func_sel = 2'b01; data_in = 8'hEE;
        @(posedge clk);
        #1;
        rst_n = 1'b1; reg_mask = '0;
        for (int i = 0; i < 3; i++) model[i] = 8'h00;
        read_all("R1 reset");
    endtask

    task automatic t_load_single();
        op(3'b001, 2'b01, 8'h12);
        op(3'b010, 2'b01, 8'h34);
        op(3'b100, 2'b01, 8'h56);
        read_all("R4 load");
    endtask

    task automatic t_mask_none();
        op(3'b000, 2'b00, 8'hFF);
        op(3'b000, 2'b01, 8'hFF);
        read_all("R2 zero mask");
        op(3'b101, 2'b10, 8'h00);
        read_all("R2 partial mask");
    endtask

    task automatic t_inc_wrap();
        op(3'b111, 2'b01, 8'hFF);
        op(3'b011, 2'b10, 8'h00);
        read_all("R5 inc wrap");
        sel_c = 2'b00; #1;
        check("R5 pc wrapped", out_c, 8'h00);
    endtask

    task automatic t_dec_wrap();
        op(3'b111, 2'b00, 8'h00);
        op(3'b110, 2'b11, 8'h00);
        read_all("R6 dec wrap");
        sel_d = 2'b10; #1;
        check("R6 sp wrapped", out_d, 8'hFF);
        op(3'b100, 2'b11, 8'h00);
        sel_d = 2'b10; #1;
        check("R6 sp second dec", out_d, 8'hFE);
    endtask

    task automatic t_multi();
        op(3'b001, 2'b01, 8'h10);
        op(3'b010, 2'b01, 8'h80);
        op(3'b100, 2'b01, 8'hC3);
        op(3'b111, 2'b10, 8'h00);
        read_all("R9 multi inc");
        op(3'b101, 2'b11, 8'h00);
        read_all("R9 multi dec");
        op(3'b110, 2'b00, 8'h77);
        read_all("R3 clear");
    endtask

    task automatic t_alias();
        op(3'b001, 2'b01, 8'hA5);
        op(3'b010, 2'b01, 8'h3C);
        op(3'b100, 2'b01, 8'h96);
        sel_c = 2'b11; sel_d = 2'b01; #1;
        check("R7 alias C", out_c, 8'hA5);
        check("R8 D with C aliased", out_d, 8'h3C);
        sel_c = 2'b10; sel_d = 2'b11; #1;
        check("R7 C sp", out_c, 8'h96);
        check("R8 alias D", out_d, 8'hA5);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) model[i] = 8'h00;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        read_all("R1 initial reset");
        t_load_single();
        t_mask_none();
        t_inc_wrap();
        t_dec_wrap();
        t_multi();
        t_alias();
        t_reset();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule